// File: doc/BRIEF.md
# Packed Color Lookup Table with Channel Widening

This block holds the color lookup table for an indexed-color display path. Software writes 32-bit words, each of which packs two 16-bit color entries. On every accepted write the block keeps the whole 32-bit word, so that it can be read back unchanged. In the same clock edge it unpacks both halves into two full 24-bit RGB entries, widening each 5-bit component to 8 bits.

A separate lookup port takes an 8-bit pixel index and returns the widened color one cycle later. This port is meant for the pixel pipeline. The bus address decode sits outside the block: only a 7-bit word index, a write strobe and the data reach this block.

Top module: `palette_ram`

## Requirements
- R1: After reset, every stored 32-bit word and every 24-bit entry reads as zero.
- R2: A write to word n updates entry 2n from data bits [15:0] and entry 2n+1 from data bits [31:16]. No other entry changes.
- R3: Within each 16-bit half, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. The lookup result carries red in [23:16], green in [15:8] and blue in [7:0].
- R4: Bit 15 of each half has no effect on the expanded entries.
- R5: Each 5-bit component is shifted left by three. The three low bits of every output channel are zero.
- R6: `raw_rdata` shows the stored word selected by `raw_idx` combinationally. From the cycle after a write, it returns exactly the 32 bits written.
- R7: Both entries of a written word change at the same clock edge. A lookup of either entry issued in the next cycle sees the new color.
- R8: A lookup presented on `lut_idx` appears on `lut_rgb` after exactly one clock edge, and `lut_rgb` holds until the next edge.
- R9: A lookup and a write that target the same entry in the same cycle return the entry's previous color.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one packed word |
| wr_idx | input | 7 | Index of the packed word being written |
| wr_data | input | 32 | Two packed 16-bit color entries |
| raw_idx | input | 7 | Word index for raw readback |
| raw_rdata | output | 32 | Stored packed word at `raw_idx` |
| lut_idx | input | 8 | Pixel index for color lookup |
| lut_rgb | output | 24 | Widened color, one cycle after `lut_idx` |

## Verification
The packing is first tried with walking single bits in every component position. Each such bit must land in exactly one output channel at the shifted position, which separates swapped fields, wrong shifts and swapped halves. Pairs of words that differ only in the two intensity bits are written and must yield identical entries, with raw readback still showing the difference. Writes to word 0 and word 127 cover the edge entries 0, 1, 254 and 255. Back-to-back write-then-lookup and same-cycle write-and-lookup on one entry separate new-value from old-value read timing. A pseudo-random pass then checks that no write disturbs the neighbouring words.

// File: rtl/palette_ram.sv
module palette_ram #(
  parameter int WORD_AW = 7,
  parameter int CH_IN   = 5,
  parameter int CH_OUT  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WORD_AW-1:0]         wr_idx,
  input  logic [2*(3*CH_IN+1)-1:0]   wr_data,
  input  logic [WORD_AW-1:0]         raw_idx,
  output logic [2*(3*CH_IN+1)-1:0]   raw_rdata,
  input  logic [WORD_AW:0]           lut_idx,
  output logic [3*CH_OUT-1:0]        lut_rgb
);
  localparam int WORDS   = 2 ** WORD_AW;
  localparam int ENTRIES = 2 * WORDS;
  localparam int HALF    = 3 * CH_IN + 1;
  localparam int RAW_W   = 2 * HALF;
  localparam int RGB_W   = 3 * CH_OUT;
  localparam int PAD     = CH_OUT - CH_IN;

  logic [RAW_W-1:0] raw_mem [WORDS];
  logic [RGB_W-1:0] lut_mem [ENTRIES];

  function automatic logic [RGB_W-1:0] widen(input logic [HALF-1:0] h);
    logic [CH_IN-1:0] red, grn, blu;
    red = h[CH_IN-1:0];
    grn = h[2*CH_IN-1:CH_IN];
    blu = h[3*CH_IN-1:2*CH_IN];
    return {red, {PAD{1'b0}}, grn, {PAD{1'b0}}, blu, {PAD{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) raw_mem[w] <= '0;
    end else if (wr_en) begin
      raw_mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) lut_mem[e] <= '0;
    end else if (wr_en) begin
      for (int h = 0; h < 2; h++)
        lut_mem[{wr_idx, h[0]}] <= widen(wr_data[h*HALF +: HALF]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lut_rgb <= '0;
    else        lut_rgb <= lut_mem[lut_idx];
  end

  assign raw_rdata = raw_mem[raw_idx];
endmodule

// File: rtl/palette_ram_chk.sv
module palette_ram_chk #(
  parameter int WORD_AW = 7,
  parameter int CH_IN   = 5,
  parameter int CH_OUT  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [WORD_AW-1:0]         wr_idx,
  input logic [2*(3*CH_IN+1)-1:0]   wr_data,
  input logic [WORD_AW-1:0]         raw_idx,
  input logic [2*(3*CH_IN+1)-1:0]   raw_rdata,
  input logic [WORD_AW:0]           lut_idx,
  input logic [3*CH_OUT-1:0]        lut_rgb
);
  localparam int HALF  = 3 * CH_IN + 1;
  localparam int RGB_W = 3 * CH_OUT;
  localparam int PAD   = CH_OUT - CH_IN;
  localparam logic [CH_OUT-1:0] CH_LOW = CH_OUT'((1 << PAD) - 1);
  localparam logic [RGB_W-1:0] LOW_MASK = {CH_LOW, CH_LOW, CH_LOW};

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  function automatic logic [RGB_W-1:0] ref_color(input logic [HALF-1:0] h);
    return {h[CH_IN-1:0], {PAD{1'b0}},
            h[2*CH_IN-1:CH_IN], {PAD{1'b0}},
            h[3*CH_IN-1:2*CH_IN], {PAD{1'b0}}};
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> (lut_rgb == '0 && raw_rdata == '0));

  assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_rgb & LOW_MASK) == '0);

  assert_raw_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (raw_idx != $past(wr_idx)) || (raw_rdata == $past(wr_data)));

  // R2, R3, R7, R8: a lookup one cycle after a write sees the unpacked half
  assert_unpack_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && $past(wr_en, 2) &&
     $past(lut_idx[WORD_AW:1]) == $past(wr_idx, 2))
    |-> lut_rgb == ($past(lut_idx[0]) ? ref_color($past(wr_data[2*HALF-1:HALF], 2))
                                      : ref_color($past(wr_data[HALF-1:0], 2))));

  assert_hold_between_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && !$past(wr_en) && $stable(lut_idx) && $past(lut_idx) == lut_idx)
    |=> $stable(lut_rgb) || $past(wr_en));
endmodule

bind palette_ram palette_ram_chk #(.WORD_AW(WORD_AW), .CH_IN(CH_IN), .CH_OUT(CH_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .raw_idx(raw_idx), .raw_rdata(raw_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
);

// File: tb/tb_palette_ram.sv
module tb_palette_ram;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [6:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  raw_idx = '0;
  logic [31:0] raw_rdata;
  logic [7:0]  lut_idx = '0;
  logic [23:0] lut_rgb;

  palette_ram dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [23:0] val; string req; } exp_t;
  exp_t exp_q[$];
  logic look_v = 0;
  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [23:0] mdl [256];
  logic [31:0] rawm [128];

  function automatic logic [23:0] spec(input logic [15:0] h);
    return {h[4:0], 3'b000, h[9:5], 3'b000, h[14:10], 3'b000};
  endfunction

  task automatic cycle(input bit we, input logic [6:0] wi, input logic [31:0] wd,
                       input bit lv, input logic [7:0] li, input string req);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    look_v = lv; lut_idx = li;
    if (lv) begin e.val = mdl[li]; e.req = req; exp_q.push_back(e); end
    if (we) begin
      rawm[wi] = wd;
      mdl[{wi, 1'b0}] = spec(wd[15:0]);
      mdl[{wi, 1'b1}] = spec(wd[31:16]);
    end
  endtask

  task automatic raw_check(input logic [6:0] idx, input string req);
    @(negedge clk);
    wr_en = 0; look_v = 0; raw_idx = idx;
    #1;
    vectors++;
    if (raw_rdata !== rawm[idx]) begin
      miscompares++;
      $display("FAIL %s raw word %0d: got %h expected %h", req, idx, raw_rdata, rawm[idx]);
    end
  endtask

  task automatic wr(input logic [6:0] wi, input logic [31:0] wd);
    cycle(1, wi, wd, 0, 8'd0, "");
  endtask

  task automatic look(input logic [7:0] li, input string req);
    cycle(0, 7'd0, 32'd0, 1, li, req);
  endtask

  always @(posedge clk) begin
    if (rst_n && look_v) begin
      exp_t e;
      #(CLK_PERIOD/4);
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL scoreboard empty: got %h expected none", lut_rgb);
      end else begin
        e = exp_q.pop_front();
        if (lut_rgb !== e.val) begin
          miscompares++;
          $display("FAIL %s lookup: got %h expected %h", e.req, lut_rgb, e.val);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    for (int i = 0; i < 128; i++) rawm[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: everything zero after reset
    raw_check(7'd0, "R1"); raw_check(7'd127, "R1"); raw_check(7'd64, "R1");
    look(8'd0, "R1"); look(8'd255, "R1"); look(8'd77, "R1");

    // R3, R5: walking bit across each component of the low half
    for (int b = 0; b < 15; b++) begin
      wr(7'd5, 32'(1) << b);
      look(8'd10, "R3");
      look(8'd11, "R2");
    end
    // R3: walking bit in the high half
    for (int b = 0; b < 15; b++) begin
      wr(7'd9, 32'(1) << (b + 16));
      look(8'd19, "R3");
      look(8'd18, "R2");
    end

    // R5: all ones in both halves
    wr(7'd3, 32'h7fff_7fff);
    look(8'd6, "R5"); look(8'd7, "R5");

    // R4: intensity bits differ, colors must match
    wr(7'd20, 32'h1234_4321);
    look(8'd40, "R4"); look(8'd41, "R4");
    wr(7'd20, 32'h9234_c321);
    look(8'd40, "R4"); look(8'd41, "R4");
    raw_check(7'd20, "R6");

    // R2, R6: boundary words 0 and 127
    wr(7'd0, 32'h0421_7c1f);
    wr(7'd127, 32'h5555_2aaa);
    look(8'd0, "R2"); look(8'd1, "R2"); look(8'd254, "R2"); look(8'd255, "R2");
    raw_check(7'd0, "R6"); raw_check(7'd127, "R6");
    look(8'd2, "R2"); look(8'd253, "R2");

    // R7: lookup in the cycle right after the write, both entries
    wr(7'd40, 32'h03e0_001f);
    look(8'd81, "R7");
    wr(7'd41, 32'h7c00_03e0);
    look(8'd82, "R7");

    // R9: same-cycle write and lookup returns old value
    cycle(1, 7'd40, 32'h1111_2222, 1, 8'd80, "R9");
    cycle(1, 7'd40, 32'h3333_4444, 1, 8'd81, "R9");
    look(8'd80, "R7"); look(8'd81, "R7");

    // R8: repeated lookups back to back with different indices
    look(8'd6, "R8"); look(8'd255, "R8"); look(8'd6, "R8"); look(8'd0, "R8");

    // pseudo-random writes with interleaved lookups and readback
    lfsr = 32'hace1_2345;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cycle(1, lfsr[6:0], lfsr ^ 32'h5a5a_a5a5, 1, lfsr[15:8], "R2");
      look(lfsr[23:16], "R2");
      if (k % 10 == 0) raw_check(lfsr[13:7], "R6");
    end
    for (int w = 0; w < 128; w += 9) raw_check(7'(w), "R6");

    @(negedge clk); wr_en = 0; look_v = 0;
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R8 pending lookups: got %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule